// File: doc/BRIEF.md
# Interleaved I/Q Input Demultiplexer

This block sits at the front of a two-channel converter datapath. It accepts sample words from either two parallel input ports (one for I, one for Q) or from a single port that carries I and Q words alternately. It delivers aligned, registered I and Q sample streams, each with its own valid strobe. A select input, whose polarity is programmable, marks the first word of each pair in interleaved mode. A control bit decides whether that first word belongs to I or to Q.

On the way through, the block can convert unsigned offset-binary words to signed two's complement. It can also silence the Q channel for real-only operation. Finally, it can stretch each sample over an upsampling factor of 1, 2, 4 or 8 output cycles, padding the extra cycles either with zeros or with copies of the sample. All configuration inputs are static levels that are changed only while no samples are in flight.

Top module: `iq_demux`

## Requirements
- R1: With `cfg_interleave`=0, each word accepted on `in_valid` produces one output sample two clocks later, with `in_a` on `out_i` and `in_b` on `out_q`, and `out_i_valid` high for that cycle.
- R2: With `cfg_interleave`=1, only `in_a` is used. A marked word opens a pair and the next unmarked word closes it. The pair appears on both outputs together, two clocks after the closing word, with a single valid cycle when the factor is 1.
- R3: In interleaved mode, `cfg_q_first`=0 sends the opening word to `out_i` and the closing word to `out_q`; `cfg_q_first`=1 swaps them.
- R4: The pair marker is `in_sel` XOR `cfg_sel_invert`, so with the invert bit at 1 a low `in_sel` marks the opening word.
- R5: A marked word that arrives while a pair is open replaces the held word, and the old word is lost. An unmarked word that arrives with no pair open is dropped and produces no output.
- R6: With `cfg_unsigned`=1 the most significant bit of every input word is inverted (offset binary to two's complement); with 0 words pass unchanged.
- R7: With `cfg_real_mode`=1, `out_q` is zero and `out_q_valid` stays low, while the I channel is unaffected. `out_q_valid` is never high without `out_i_valid`.
- R8: `cfg_interp` code c (0..3) gives a factor of 2^c. After each new sample, the block emits 2^c-1 further output cycles with the valid strobes high, then goes idle.
- R9: During those fill cycles, `cfg_zero_stuff`=1 outputs zero on both channels; `cfg_zero_stuff`=0 repeats the last sample.
- R10: After reset, the outputs are zero, both valid strobes are low, and any half-received pair is discarded.
- R11: A new sample reaching the output stage during fill cycles is emitted at once and restarts the fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interleave | input | 1 | 1: both channels arrive on `in_a` |
| cfg_q_first | input | 1 | 1: opening word of a pair goes to Q |
| cfg_sel_invert | input | 1 | Inverts the sense of `in_sel` |
| cfg_unsigned | input | 1 | 1: inputs are offset binary |
| cfg_real_mode | input | 1 | 1: Q channel silenced |
| cfg_zero_stuff | input | 1 | 1: fill with zeros, 0: fill by repeating |
| cfg_interp | input | 2 | Upsampling factor code, factor 2^code |
| in_valid | input | 1 | Input word strobe |
| in_sel | input | 1 | Pair marker / select |
| in_a | input | SAMPLE_W | First input port |
| in_b | input | SAMPLE_W | Second input port (parallel mode) |
| out_i | output | SAMPLE_W | I sample |
| out_q | output | SAMPLE_W | Q sample |
| out_i_valid | output | 1 | I sample strobe |
| out_q_valid | output | 1 | Q sample strobe |

## Verification
If the pairing state is wrong, for example when a word is left held after a realign, an orphan is accepted, or the swap is applied the wrong way, the fault shows two clocks after the closing word. It appears either as swapped or stale values, or as a valid pulse where none should be. A wrong fill counter shows on the valid strobe at the end of a stretched sample, and a wrong fill source shows on the data in the first fill cycle. Format and real-mode faults reach the outputs in the very next result, so every directed case checks the exact cycle and the cycle after it.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;

   typedef enum logic [1:0] {
      UPS_X1 = 2'd0,
      UPS_X2 = 2'd1,
      UPS_X4 = 2'd2,
      UPS_X8 = 2'd3
   } ups_code_e;

   localparam int FILL_W = 3;

   // number of extra output cycles after a new sample
   function automatic logic [FILL_W-1:0] fill_cycles(input logic [1:0] code);
      logic [FILL_W:0] f;
      f = (FILL_W+1)'(1) << code;
      return FILL_W'(f - 1'b1);
   endfunction

endpackage

// File: rtl/iq_fmt.sv
module iq_fmt #(
   parameter int W = 16
) (
   input  logic         offset_bin,
   input  logic [W-1:0] word_in,
   output logic [W-1:0] word_out
);
   always_comb begin
      word_out        = word_in;
      word_out[W-1]   = word_in[W-1] ^ offset_bin;
   end
endmodule

// File: rtl/iq_pairer.sv
module iq_pairer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         interleave,
   input  logic         q_first,
   input  logic         marker,
   input  logic         word_valid,
   input  logic [W-1:0] word_a,
   input  logic [W-1:0] word_b,
   output logic         pair_valid,
   output logic [W-1:0] pair_i,
   output logic [W-1:0] pair_q
);
   logic [W-1:0] held_word;
   logic         held_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_word  <= '0;
         held_ok    <= 1'b0;
         pair_valid <= 1'b0;
         pair_i     <= '0;
         pair_q     <= '0;
      end else begin
         pair_valid <= 1'b0;
         if (!interleave) begin
            held_ok <= 1'b0;
            if (word_valid) begin
               pair_valid <= 1'b1;
               pair_i     <= word_a;
               pair_q     <= word_b;
            end
         end else if (word_valid) begin
            if (marker) begin
               held_word <= word_a;
               held_ok   <= 1'b1;
            end else if (held_ok) begin
               held_ok    <= 1'b0;
               pair_valid <= 1'b1;
               if (q_first) begin
                  pair_i <= word_a;
                  pair_q <= held_word;
               end else begin
                  pair_i <= held_word;
                  pair_q <= word_a;
               end
            end
         end
      end
   end
endmodule

// File: rtl/iq_stuffer.sv
module iq_stuffer
   import iq_demux_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         real_mode,
   input  logic         zero_fill,
   input  logic [1:0]   ups_code,
   input  logic         pair_valid,
   input  logic [W-1:0] pair_i,
   input  logic [W-1:0] pair_q,
   output logic [W-1:0] out_i,
   output logic [W-1:0] out_q,
   output logic         out_i_valid,
   output logic         out_q_valid
);
   logic [FILL_W-1:0] fill_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_i       <= '0;
         out_q       <= '0;
         out_i_valid <= 1'b0;
         out_q_valid <= 1'b0;
         fill_left   <= '0;
      end else if (pair_valid) begin
         out_i       <= pair_i;
         out_q       <= real_mode ? '0 : pair_q;
         out_i_valid <= 1'b1;
         out_q_valid <= !real_mode;
         fill_left   <= fill_cycles(ups_code);
      end else if (fill_left != '0) begin
         fill_left   <= fill_left - 1'b1;
         out_i_valid <= 1'b1;
         out_q_valid <= !real_mode;
         if (zero_fill) begin
            out_i <= '0;
            out_q <= '0;
         end else if (real_mode) begin
            out_q <= '0;
         end
      end else begin
         out_i_valid <= 1'b0;
         out_q_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/iq_demux.sv
module iq_demux
   import iq_demux_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_interleave,
   input  logic                cfg_q_first,
   input  logic                cfg_sel_invert,
   input  logic                cfg_unsigned,
   input  logic                cfg_real_mode,
   input  logic                cfg_zero_stuff,
   input  logic [1:0]          cfg_interp,
   input  logic                in_valid,
   input  logic                in_sel,
   input  logic [SAMPLE_W-1:0] in_a,
   input  logic [SAMPLE_W-1:0] in_b,
   output logic [SAMPLE_W-1:0] out_i,
   output logic [SAMPLE_W-1:0] out_q,
   output logic                out_i_valid,
   output logic                out_q_valid
);
   localparam int NPORTS = 2;

   if (SAMPLE_W < 12 || SAMPLE_W > 16) begin : g_bad_width
      $error("iq_demux: SAMPLE_W must lie in 12..16");
   end

   logic [SAMPLE_W-1:0] raw_word [NPORTS];
   logic [SAMPLE_W-1:0] fmt_word [NPORTS];
   logic                pair_marker;
   logic                pair_valid;
   logic [SAMPLE_W-1:0] pair_i;
   logic [SAMPLE_W-1:0] pair_q;

   assign raw_word[0] = in_a;
   assign raw_word[1] = in_b;
   assign pair_marker = in_sel ^ cfg_sel_invert;

   for (genvar p = 0; p < NPORTS; p++) begin : g_fmt
      iq_fmt #(.W(SAMPLE_W)) u_fmt (
         .offset_bin (cfg_unsigned),
         .word_in    (raw_word[p]),
         .word_out   (fmt_word[p])
      );
   end

   iq_pairer #(.W(SAMPLE_W)) u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .interleave (cfg_interleave),
      .q_first    (cfg_q_first),
      .marker     (pair_marker),
      .word_valid (in_valid),
      .word_a     (fmt_word[0]),
      .word_b     (fmt_word[1]),
      .pair_valid (pair_valid),
      .pair_i     (pair_i),
      .pair_q     (pair_q)
   );

   iq_stuffer #(.W(SAMPLE_W)) u_stuff (
      .clk         (clk),
      .rst_n       (rst_n),
      .real_mode   (cfg_real_mode),
      .zero_fill   (cfg_zero_stuff),
      .ups_code    (cfg_interp),
      .pair_valid  (pair_valid),
      .pair_i      (pair_i),
      .pair_q      (pair_q),
      .out_i       (out_i),
      .out_q       (out_q),
      .out_i_valid (out_i_valid),
      .out_q_valid (out_q_valid)
   );
endmodule

// File: rtl/iq_demux_chk.sv
module iq_demux_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cfg_interleave,
   input logic         cfg_sel_invert,
   input logic         cfg_real_mode,
   input logic         cfg_zero_stuff,
   input logic         in_valid,
   input logic         in_sel,
   input logic         pair_valid,
   input logic [W-1:0] out_i,
   input logic [W-1:0] out_q,
   input logic         out_i_valid,
   input logic         out_q_valid
);
   assert_par_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_interleave) |=> ##1 out_i_valid);

   // R2 / R5: a marked word opens a pair and never completes one
   assert_open_no_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_interleave && in_valid && (in_sel ^ cfg_sel_invert)) |=> !pair_valid);

   assert_pair_emits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> out_i_valid);

   assert_real_q_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_real_mode) |-> (!out_q_valid && out_q == '0));

   assert_q_needs_i_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_q_valid |-> out_i_valid);

   assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!pair_valid) && out_i_valid && $past(cfg_zero_stuff)) |-> (out_i == '0));

   assert_repeat_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!pair_valid) && out_i_valid && !$past(cfg_zero_stuff)) |-> $stable(out_i));
endmodule

bind iq_demux iq_demux_chk #(.W(SAMPLE_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_interleave (cfg_interleave),
   .cfg_sel_invert (cfg_sel_invert),
   .cfg_real_mode  (cfg_real_mode),
   .cfg_zero_stuff (cfg_zero_stuff),
   .in_valid       (in_valid),
   .in_sel         (in_sel),
   .pair_valid     (pair_valid),
   .out_i          (out_i),
   .out_q          (out_q),
   .out_i_valid    (out_i_valid),
   .out_q_valid    (out_q_valid)
);

// File: tb/iq_demux_tb.sv
`timescale 1ns/1ps
module iq_demux_tb;
   localparam int W = 16;

   typedef struct packed {
      logic         uns;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] ei;
      logic [W-1:0] eq;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'h1234, 16'hABCD, 16'h1234, 16'hABCD},
      '{1'b1, 16'h8000, 16'h0000, 16'h0000, 16'h8000},
      '{1'b1, 16'hFFFF, 16'h7FFF, 16'h7FFF, 16'hFFFF},
      '{1'b0, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF},
      '{1'b1, 16'h1234, 16'hC000, 16'h9234, 16'h4000},
      '{1'b0, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_interleave = 0, cfg_q_first = 0, cfg_sel_invert = 0, cfg_unsigned = 0;
   logic cfg_real_mode = 0, cfg_zero_stuff = 0;
   logic [1:0] cfg_interp = 2'd0;
   logic in_valid = 0, in_sel = 0;
   logic [W-1:0] in_a = '0, in_b = '0;
   logic [W-1:0] out_i, out_q;
   logic out_i_valid, out_q_valid;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   iq_demux #(.SAMPLE_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_interleave(cfg_interleave), .cfg_q_first(cfg_q_first),
      .cfg_sel_invert(cfg_sel_invert), .cfg_unsigned(cfg_unsigned),
      .cfg_real_mode(cfg_real_mode), .cfg_zero_stuff(cfg_zero_stuff),
      .cfg_interp(cfg_interp), .in_valid(in_valid), .in_sel(in_sel),
      .in_a(in_a), .in_b(in_b), .out_i(out_i), .out_q(out_q),
      .out_i_valid(out_i_valid), .out_q_valid(out_q_valid)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic word(input logic [W-1:0] a, input logic [W-1:0] b, input logic sel);
      in_valid = 1'b1; in_a = a; in_b = b; in_sel = sel;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic defaults();
      cfg_interleave = 0; cfg_q_first = 0; cfg_sel_invert = 0; cfg_unsigned = 0;
      cfg_real_mode = 0; cfg_zero_stuff = 0; cfg_interp = 2'd0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R10 reset state
      check("R10 out_i", 32'(out_i), 32'h0);
      check("R10 out_q", 32'(out_q), 32'h0);
      check("R10 valids", {30'd0, out_i_valid, out_q_valid}, 32'h0);

      // table walk: parallel mode, formats (R1, R6)
      for (int k = 0; k < NV; k++) begin
         cfg_unsigned = VECS[k].uns;
         word(VECS[k].a, VECS[k].b, 1'b0);
         @(negedge clk);
         check("R1 R6 out_i", 32'(out_i), 32'(VECS[k].ei));
         check("R1 R6 out_q", 32'(out_q), 32'(VECS[k].eq));
         check("R1 valids", {30'd0, out_i_valid, out_q_valid}, 32'h3);
         @(negedge clk);
         check("R1 single pulse", 32'(out_i_valid), 32'h0);
      end
      defaults();

      // R2 interleaved, opening word to I
      cfg_interleave = 1;
      word(16'h1111, 16'hDEAD, 1'b1);
      check("R2 no early valid", 32'(out_i_valid), 32'h0);
      word(16'h2222, 16'hDEAD, 1'b0);
      check("R2 still idle", 32'(out_i_valid), 32'h0);
      @(negedge clk);
      check("R2 out_i", 32'(out_i), 32'h1111);
      check("R2 out_q", 32'(out_q), 32'h2222);
      check("R2 valids", {30'd0, out_i_valid, out_q_valid}, 32'h3);
      @(negedge clk);
      check("R2 one pulse", 32'(out_i_valid), 32'h0);

      // R3 opening word to Q
      cfg_q_first = 1;
      word(16'h3333, 16'h0, 1'b1);
      word(16'h4444, 16'h0, 1'b0);
      @(negedge clk);
      check("R3 out_i", 32'(out_i), 32'h4444);
      check("R3 out_q", 32'(out_q), 32'h3333);
      cfg_q_first = 0;
      @(negedge clk);

      // R4 inverted marker
      cfg_sel_invert = 1;
      word(16'h5555, 16'h0, 1'b0);
      word(16'h6666, 16'h0, 1'b1);
      @(negedge clk);
      check("R4 out_i", 32'(out_i), 32'h5555);
      check("R4 out_q", 32'(out_q), 32'h6666);
      cfg_sel_invert = 0;
      @(negedge clk);

      // R5 realign: second marked word replaces the first
      word(16'h7777, 16'h0, 1'b1);
      word(16'h8888, 16'h0, 1'b1);
      check("R5 no pair on realign", 32'(out_i_valid), 32'h0);
      word(16'h9999, 16'h0, 1'b0);
      check("R5 no pair on realign 2", 32'(out_i_valid), 32'h0);
      @(negedge clk);
      check("R5 out_i", 32'(out_i), 32'h8888);
      check("R5 out_q", 32'(out_q), 32'h9999);
      @(negedge clk);
      // R5 orphan unmarked word dropped
      word(16'hAAAA, 16'h0, 1'b0);
      @(negedge clk);
      check("R5 orphan dropped", 32'(out_i_valid), 32'h0);
      @(negedge clk);
      check("R5 orphan dropped later", 32'(out_i_valid), 32'h0);

      // R10 reset discards a held word
      word(16'hBBBB, 16'h0, 1'b1);
      do_reset();
      cfg_interleave = 1;
      word(16'hCCCC, 16'h0, 1'b0);
      @(negedge clk);
      check("R10 held discarded", 32'(out_i_valid), 32'h0);
      defaults();

      // R7 real mode
      cfg_real_mode = 1;
      word(16'h0101, 16'h0202, 1'b0);
      @(negedge clk);
      check("R7 out_i", 32'(out_i), 32'h0101);
      check("R7 out_q zero", 32'(out_q), 32'h0);
      check("R7 valids", {30'd0, out_i_valid, out_q_valid}, 32'h2);
      defaults();
      @(negedge clk);

      // R8 R9 factor 4 with zeros
      cfg_interp = 2'd2; cfg_zero_stuff = 1;
      word(16'h4321, 16'h1234, 1'b0);
      @(negedge clk);
      check("R8 sample i", 32'(out_i), 32'h4321);
      check("R8 sample q", 32'(out_q), 32'h1234);
      for (int f = 0; f < 3; f++) begin
         @(negedge clk);
         check("R9 zero fill", {out_i, out_q}, 32'h0);
         check("R8 fill valid", {30'd0, out_i_valid, out_q_valid}, 32'h3);
      end
      @(negedge clk);
      check("R8 idle after fill", {30'd0, out_i_valid, out_q_valid}, 32'h0);

      // R8 R9 factor 2 with repeat
      cfg_interp = 2'd1; cfg_zero_stuff = 0;
      word(16'h5A5A, 16'hA5A5, 1'b0);
      @(negedge clk);
      check("R8 x2 sample", {out_i, out_q}, 32'h5A5AA5A5);
      @(negedge clk);
      check("R9 repeat fill", {out_i, out_q}, 32'h5A5AA5A5);
      check("R8 x2 fill valid", 32'(out_i_valid), 32'h1);
      @(negedge clk);
      check("R8 x2 idle", 32'(out_i_valid), 32'h0);

      // R11 new sample during fill restarts the count (factor 8)
      cfg_interp = 2'd3; cfg_zero_stuff = 1;
      word(16'h1000, 16'h2000, 1'b0);
      @(negedge clk);
      word(16'h3000, 16'h4000, 1'b0);
      check("R11 fill before new", {out_i, out_q}, 32'h0);
      @(negedge clk);
      check("R11 new sample", {out_i, out_q}, 32'h30004000);
      for (int f = 0; f < 7; f++) @(negedge clk);
      check("R11 last fill valid", 32'(out_i_valid), 32'h1);
      @(negedge clk);
      check("R11 idle after restart", 32'(out_i_valid), 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule